// File: doc/BRIEF.md
# Indexed-Colour Framebuffer Register Slave

This block is a small memory-mapped slave that stores an 8-bit colour index for every pixel of a display and turns those indices into 24-bit RGB values for a scan-out reader. Software does not address pixels linearly. It first loads a row coordinate and a column coordinate into two 16-bit registers. A third word offset then reads or writes the index of the pixel those coordinates select. A fourth offset accepts writes only. Each write there raises a one-cycle refresh request that display logic downstream may use to take a new frame.

The display geometry is set by parameters. The full-size setting is 320 columns by 240 rows. The default elaboration uses a reduced 40 by 30 geometry so the pixel store stays small. A separate scan port reads any pixel by its linear address, row times width plus column, and passes the stored index through an eight-colour palette. Indices with no palette entry come out black.

Top module: `fb_indexed`

## Requirements
- R1: After reset the row and column registers read 0, the refresh strobe is low, and bus_ready is low while bus_sel is low.
- R2: Offset 0 is the row register and offset 1 is the column register. A write loads all 16 bits of bus_wdata, and a read returns the stored value on bus_rdata.
- R3: A write to offset 2 stores bus_wdata[7:0] at linear address row*DISP_W+col. A read of offset 2 returns that byte zero-extended to 16 bits, with bus_ready low in the first access cycle and high in the second.
- R4: Each write to offset 3 makes refresh_pulse high for exactly the one cycle after the write edge. refresh_pulse is low at all other times.
- R5: A read of offset 3 or above, or a write of offset 4 or above, completes at once with bus_err and bus_ready high and bus_rdata 0. It changes no register.
- R6: When row is DISP_H or more, or col is DISP_W or more, an offset-2 access completes at once with bus_err high and bus_rdata 0. The pixel store is left unchanged. Loading out-of-range coordinates into the registers is not itself an error.
- R7: With scan_en high, the RGB outputs one cycle later show the palette colour of the index stored at scan_addr. The colours are: 0 black; 1 red 127; 2 green 127; 3 blue 127; 4 red 255; 5 green 255; 6 blue 255; 7 white (255,255,255). Channels not named are 0.
- R8: Stored indices 8 to 255 appear on the scan outputs as black (0,0,0).
- R9: Every access other than a valid pixel read completes with bus_ready high in the same cycle that bus_sel is first seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access request, held until bus_ready |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | OFS_W | Word offset within the block |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Access completes in this cycle |
| bus_err | output | 1 | Invalid offset or out-of-range coordinate |
| refresh_pulse | output | 1 | One-cycle refresh request |
| scan_en | input | 1 | Scan read enable |
| scan_addr | input | PIX_AW | Linear pixel address for scan read |
| scan_red | output | 8 | Red channel of scanned pixel |
| scan_green | output | 8 | Green channel of scanned pixel |
| scan_blue | output | 8 | Blue channel of scanned pixel |

## Verification
Some results appear in the cycle the access is presented: register read data, bus_err, and bus_ready for everything except a pixel read. The bench samples these one nanosecond after the falling edge where it drove the access. Pixel read data and bus_ready arrive one rising edge later, and the access task counts the wait cycles it sees so the single wait state is checked as well as the data. The refresh strobe and the scan colour lag their cause by one rising edge. The bench reads them at the falling edge after that edge, and it checks the strobe low both before and after its cycle.

// File: rtl/fb_pkg.sv
`timescale 1ns/1ps
package fb_pkg;

  localparam int OFS_ROW     = 0;
  localparam int OFS_COL     = 1;
  localparam int OFS_PIX     = 2;
  localparam int OFS_REFRESH = 3;

  typedef struct packed {
    logic [7:0] red;
    logic [7:0] green;
    logic [7:0] blue;
  } rgb_t;

  // Colour for a palette slot; slots past the defined set are black.
  function automatic rgb_t colour_of(input int slot);
    rgb_t c;
    c = '0;
    case (slot)
      1: c.red   = 8'd127;
      2: c.green = 8'd127;
      3: c.blue  = 8'd127;
      4: c.red   = 8'd255;
      5: c.green = 8'd255;
      6: c.blue  = 8'd255;
      7: c       = '{red: 8'd255, green: 8'd255, blue: 8'd255};
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/fb_coord_regs.sv
`timescale 1ns/1ps
module fb_coord_regs #(
  parameter int DISP_W = 40,
  parameter int DISP_H = 30,
  parameter int DATA_W = 16,
  parameter int PIX_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_we,
  input  logic              col_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] row_q,
  output logic [DATA_W-1:0] col_q,
  output logic              in_range,
  output logic [PIX_AW-1:0] pix_addr
);

  logic [DATA_W-1:0] row_d;
  logic [DATA_W-1:0] col_d;
  logic [31:0]       lin;

  always_comb begin
    row_d = row_q;
    col_d = col_q;
    if (row_we) row_d = wdata;
    if (col_we) col_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  always_comb begin
    in_range = (32'(row_q) < 32'(DISP_H)) && (32'(col_q) < 32'(DISP_W));
    lin      = 32'(row_q) * 32'(DISP_W) + 32'(col_q);
    pix_addr = in_range ? lin[PIX_AW-1:0] : '0;
  end

  assert_row_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    row_we |=> (row_q == $past(wdata)));

  assert_col_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    col_we |=> (col_q == $past(wdata)));

endmodule

// File: rtl/fb_bus_ctrl.sv
`timescale 1ns/1ps
module fb_bus_ctrl
  import fb_pkg::*;
#(
  parameter int OFS_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              we,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              in_range,
  input  logic [DATA_W-1:0] row_q,
  input  logic [DATA_W-1:0] col_q,
  input  logic [7:0]        pix_q,
  output logic              row_we,
  output logic              col_we,
  output logic              pix_we,
  output logic              pix_rd,
  output logic              ready,
  output logic              err,
  output logic [DATA_W-1:0] rdata,
  output logic              refresh_pulse
);

  logic is_row, is_col, is_pix, is_ref, bad_ofs, bad_xy;
  logic pend_q, pend_d;
  logic ref_d;

  always_comb begin
    is_row  = (ofs == OFS_W'(OFS_ROW));
    is_col  = (ofs == OFS_W'(OFS_COL));
    is_pix  = (ofs == OFS_W'(OFS_PIX));
    is_ref  = (ofs == OFS_W'(OFS_REFRESH));
    bad_ofs = we ? (ofs > OFS_W'(OFS_REFRESH)) : (ofs > OFS_W'(OFS_PIX));
    bad_xy  = is_pix && !in_range;

    err     = sel && (bad_ofs || bad_xy);
    row_we  = sel && we && is_row;
    col_we  = sel && we && is_col;
    pix_we  = sel && we && is_pix && in_range;
    pix_rd  = sel && !we && is_pix && in_range;
    ref_d   = sel && we && is_ref;

    ready   = sel && (!pix_rd || pend_q);
    pend_d  = pix_rd && !pend_q;

    rdata = '0;
    if (sel && !err && !we) begin
      if (is_row)      rdata = row_q;
      else if (is_col) rdata = col_q;
      else if (is_pix) rdata = DATA_W'(pix_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q        <= 1'b0;
      refresh_pulse <= 1'b0;
    end else begin
      pend_q        <= pend_d;
      refresh_pulse <= ref_d;
    end
  end

  assert_no_update_on_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !(row_we || col_we || pix_we || refresh_pulse && $past(err && we && !is_ref)));

  assert_error_completes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ready);

  assert_single_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q);

  assert_refresh_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_pulse |-> $past(sel && we && ready && !err));

endmodule

// File: rtl/fb_pixel_store.sv
`timescale 1ns/1ps
module fb_pixel_store #(
  parameter int DEPTH  = 1200,
  parameter int PIX_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PIX_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic [PIX_AW-1:0] rd_addr,
  output logic [7:0]        rd_q,
  input  logic              scan_en,
  input  logic [PIX_AW-1:0] scan_addr,
  output logic [7:0]        scan_q
);

  logic [7:0] mem [DEPTH];
  logic       scan_ok;
  logic [7:0] rd_d, scan_d;

  always_comb begin
    scan_ok = ({1'b0, scan_addr} < (PIX_AW+1)'(DEPTH));
    rd_d    = rd_en ? mem[rd_addr] : rd_q;
    scan_d  = scan_q;
    if (scan_en) scan_d = scan_ok ? mem[scan_addr] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= '0;
      scan_q <= '0;
    end else begin
      rd_q   <= rd_d;
      scan_q <= scan_d;
    end
  end

  assert_write_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ({1'b0, wr_addr} < (PIX_AW+1)'(DEPTH)));

  assert_read_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ({1'b0, rd_addr} < (PIX_AW+1)'(DEPTH)));

endmodule

// File: rtl/fb_palette_lut.sv
`timescale 1ns/1ps
module fb_palette_lut
  import fb_pkg::*;
#(
  parameter int NUM_COLOURS = 8
) (
  input  logic [7:0] index,
  output rgb_t       colour
);

  localparam int SEL_W = (NUM_COLOURS > 1) ? $clog2(NUM_COLOURS) : 1;

  rgb_t table_q [NUM_COLOURS];

  for (genvar g = 0; g < NUM_COLOURS; g++) begin : g_entry
    assign table_q[g] = colour_of(g);
  end

  always_comb begin
    if (32'(index) < 32'(NUM_COLOURS)) colour = table_q[index[SEL_W-1:0]];
    else                               colour = '0;
  end

endmodule

// File: rtl/fb_indexed.sv
`timescale 1ns/1ps
module fb_indexed
  import fb_pkg::*;
#(
  parameter int DISP_W      = 40,
  parameter int DISP_H      = 30,
  parameter int OFS_W       = 4,
  parameter int DATA_W      = 16,
  parameter int NUM_COLOURS = 8,
  localparam int DEPTH      = DISP_W * DISP_H,
  localparam int PIX_AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [OFS_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              bus_err,
  output logic              refresh_pulse,
  input  logic              scan_en,
  input  logic [PIX_AW-1:0] scan_addr,
  output logic [7:0]        scan_red,
  output logic [7:0]        scan_green,
  output logic [7:0]        scan_blue
);

  logic [1:0]        rst_sync;
  logic              srst_n;
  logic              row_we, col_we, pix_we, pix_rd, in_range;
  logic [DATA_W-1:0] row_q, col_q;
  logic [PIX_AW-1:0] pix_addr;
  logic [7:0]        pix_q, scan_q;
  rgb_t              colour;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign srst_n = rst_sync[1];

  fb_coord_regs #(
    .DISP_W(DISP_W), .DISP_H(DISP_H), .DATA_W(DATA_W), .PIX_AW(PIX_AW)
  ) u_coord (
    .clk(clk), .rst_n(srst_n), .row_we(row_we), .col_we(col_we),
    .wdata(bus_wdata), .row_q(row_q), .col_q(col_q),
    .in_range(in_range), .pix_addr(pix_addr)
  );

  fb_bus_ctrl #(.OFS_W(OFS_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(srst_n), .sel(bus_sel), .we(bus_we), .ofs(bus_addr),
    .in_range(in_range), .row_q(row_q), .col_q(col_q), .pix_q(pix_q),
    .row_we(row_we), .col_we(col_we), .pix_we(pix_we), .pix_rd(pix_rd),
    .ready(bus_ready), .err(bus_err), .rdata(bus_rdata),
    .refresh_pulse(refresh_pulse)
  );

  fb_pixel_store #(.DEPTH(DEPTH), .PIX_AW(PIX_AW)) u_store (
    .clk(clk), .rst_n(srst_n),
    .wr_en(pix_we), .wr_addr(pix_addr), .wr_data(bus_wdata[7:0]),
    .rd_en(pix_rd), .rd_addr(pix_addr), .rd_q(pix_q),
    .scan_en(scan_en), .scan_addr(scan_addr), .scan_q(scan_q)
  );

  fb_palette_lut #(.NUM_COLOURS(NUM_COLOURS)) u_pal (
    .index(scan_q), .colour(colour)
  );

  assign scan_red   = colour.red;
  assign scan_green = colour.green;
  assign scan_blue  = colour.blue;

endmodule

// File: tb/fb_indexed_test.sv
`timescale 1ns/1ps
module fb_indexed_test;

  localparam int CYC = 20;
  localparam int NV  = 30;

  logic        clk, rst_n;
  logic        bus_sel, bus_we;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        bus_ready, bus_err, refresh_pulse;
  logic        scan_en;
  logic [10:0] scan_addr;
  logic [7:0]  scan_red, scan_green, scan_blue;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  fb_indexed uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .refresh_pulse(refresh_pulse),
    .scan_en(scan_en), .scan_addr(scan_addr),
    .scan_red(scan_red), .scan_green(scan_green), .scan_blue(scan_blue)
  );

  initial clk = 1'b0;
  always #(CYC/2) clk = ~clk;

  // {we, ofs[3:0], wdata[15:0], exp_rdata[15:0], exp_err, req[3:0]}
  localparam logic [41:0] VEC [NV] = '{
    {1'b1, 4'd0, 16'h0005, 16'h0000, 1'b0, 4'd2},
    {1'b1, 4'd1, 16'h0007, 16'h0000, 1'b0, 4'd2},
    {1'b0, 4'd0, 16'h0000, 16'h0005, 1'b0, 4'd2},
    {1'b0, 4'd1, 16'h0000, 16'h0007, 1'b0, 4'd2},
    {1'b1, 4'd2, 16'hAB12, 16'h0000, 1'b0, 4'd3},
    {1'b0, 4'd2, 16'h0000, 16'h0012, 1'b0, 4'd3},
    {1'b1, 4'd1, 16'h0027, 16'h0000, 1'b0, 4'd2},
    {1'b1, 4'd2, 16'h0055, 16'h0000, 1'b0, 4'd3},
    {1'b0, 4'd2, 16'h0000, 16'h0055, 1'b0, 4'd3},
    {1'b1, 4'd1, 16'h0000, 16'h0000, 1'b0, 4'd2},
    {1'b1, 4'd2, 16'h0021, 16'h0000, 1'b0, 4'd3},
    {1'b1, 4'd0, 16'h0004, 16'h0000, 1'b0, 4'd2},
    {1'b1, 4'd1, 16'h0028, 16'h0000, 1'b0, 4'd6},
    {1'b1, 4'd2, 16'h0077, 16'h0000, 1'b1, 4'd6},
    {1'b0, 4'd2, 16'h0000, 16'h0000, 1'b1, 4'd6},
    {1'b0, 4'd1, 16'h0000, 16'h0028, 1'b0, 4'd6},
    {1'b1, 4'd0, 16'h0005, 16'h0000, 1'b0, 4'd2},
    {1'b1, 4'd1, 16'h0000, 16'h0000, 1'b0, 4'd2},
    {1'b0, 4'd2, 16'h0000, 16'h0021, 1'b0, 4'd6},
    {1'b1, 4'd0, 16'h001E, 16'h0000, 1'b0, 4'd6},
    {1'b1, 4'd2, 16'h0066, 16'h0000, 1'b1, 4'd6},
    {1'b0, 4'd2, 16'h0000, 16'h0000, 1'b1, 4'd6},
    {1'b0, 4'd3, 16'h0000, 16'h0000, 1'b1, 4'd5},
    {1'b0, 4'd7, 16'h0000, 16'h0000, 1'b1, 4'd5},
    {1'b1, 4'd4, 16'h1234, 16'h0000, 1'b1, 4'd5},
    {1'b1, 4'd15,16'h0009, 16'h0000, 1'b1, 4'd5},
    {1'b0, 4'd0, 16'h0000, 16'h001E, 1'b0, 4'd5},
    {1'b1, 4'd1, 16'h0007, 16'h0000, 1'b0, 4'd2},
    {1'b1, 4'd0, 16'h0005, 16'h0000, 1'b0, 4'd2},
    {1'b0, 4'd2, 16'h0000, 16'h0012, 1'b0, 4'd3}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Drives one access at a falling edge and holds it until bus_ready.
  task automatic bus_op(input bit we, input logic [3:0] ofs, input logic [15:0] wd,
                        output logic [15:0] rd, output bit er, output int waits);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = ofs; bus_wdata = wd;
    waits = 0;
    #1;
    while (!bus_ready && waits < 8) begin
      waits++;
      @(negedge clk);
      #1;
    end
    rd = bus_rdata;
    er = bus_err;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  function automatic logic [23:0] want_rgb(input int idx);
    case (idx)
      1: return {8'd127, 8'd0, 8'd0};
      2: return {8'd0, 8'd127, 8'd0};
      3: return {8'd0, 8'd0, 8'd127};
      4: return {8'd255, 8'd0, 8'd0};
      5: return {8'd0, 8'd255, 8'd0};
      6: return {8'd0, 8'd0, 8'd255};
      7: return {8'd255, 8'd255, 8'd255};
      default: return 24'h0;
    endcase
  endfunction

  initial begin
    #(CYC * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    bit er;
    int waits;
    int idx_list [11];

    bus_sel = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0;
    scan_en = 0; scan_addr = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    #1;
    check(refresh_pulse == 1'b0, "R1", "refresh after reset", refresh_pulse, 0);
    check(bus_ready == 1'b0, "R1", "ready idle", bus_ready, 0);
    bus_op(1'b0, 4'd0, 16'h0, rd, er, waits);
    check(rd == 16'h0, "R1", "row after reset", rd, 0);
    bus_op(1'b0, 4'd1, 16'h0, rd, er, waits);
    check(rd == 16'h0, "R1", "col after reset", rd, 0);

    // Table walk covering R2 R3 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      logic [41:0] v;
      string tag;
      int exp_w;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      bus_op(v[41], v[40:37], v[36:21], rd, er, waits);
      check(er == v[4], tag, "err", er, v[4]);
      if (!v[41]) check(rd == v[20:5], tag, "rdata", rd, v[20:5]);
      exp_w = (!v[41] && v[40:37] == 4'd2 && !v[4]) ? 1 : 0;
      check(waits == exp_w, (exp_w == 1) ? "R3" : "R9", "wait cycles", waits, exp_w);
    end

    // R4 refresh strobe
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 4'd3; bus_wdata = 16'h0;
    #1;
    check(bus_ready && !bus_err, "R4", "refresh write ready", bus_ready, 1);
    check(refresh_pulse == 1'b0, "R4", "pulse before edge", refresh_pulse, 0);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    #1;
    check(refresh_pulse == 1'b1, "R4", "pulse after edge", refresh_pulse, 1);
    @(negedge clk);
    #1;
    check(refresh_pulse == 1'b0, "R4", "pulse one cycle", refresh_pulse, 0);

    // R7 R8 scan palette: indices at row 0 columns 0..10
    idx_list = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 200, 255};
    bus_op(1'b1, 4'd0, 16'h0, rd, er, waits);
    for (int c = 0; c < 11; c++) begin
      bus_op(1'b1, 4'd1, 16'(c), rd, er, waits);
      bus_op(1'b1, 4'd2, 16'(idx_list[c]), rd, er, waits);
    end
    for (int c = 0; c < 11; c++) begin
      logic [23:0] got, exp;
      @(negedge clk);
      scan_en = 1; scan_addr = 11'(c);
      @(negedge clk);
      scan_en = 0;
      #1;
      got = {scan_red, scan_green, scan_blue};
      exp = want_rgb(idx_list[c]);
      check(got == exp, (c < 8) ? "R7" : "R8", "scan colour", got, exp);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule